// File: doc/BRIEF.md
# TLB Refill Page Walker

This block services a translation miss by reading one page-table entry from memory and installing it in a TLB. It takes the missing virtual address, a flag that says whether the miss came from the data or the instruction side, and the page-table base register. From these it forms the virtual address of the entry. It sends that address to an external lookup unit as a ring-0 data read, with nested walking disabled. If the lookup succeeds, it issues one 32-bit read to memory through a request/grant/response port.

On a committed refill, the block writes the entry into one of four rotating refill ways. In the same cycle it loads the fault-address register with the missing address. It then reports completion, together with the translated physical address and the entry's ring.

A probe request builds the same translation but leaves the TLB, the fault-address register and the way rotation untouched. Only one walk runs at a time, and requests that arrive while the block is busy are dropped.

Top module: `tlb_refill_walker`

## Requirements
- R1: After reset, busy, lk_req, mem_req, tlb_we, excv_we, done and fail are all low.
- R2: The lookup request carries the entry address (pt_base | (req_vaddr >> 10)) with bits [1:0] forced to zero, and it stays asserted until lk_ack.
- R3: When the lookup answers with lk_ok low, the walk ends with fail high and fail_cause equal to lk_cause. No memory request and no TLB write occur.
- R4: After a successful lookup, exactly one memory read is issued, at address lk_paddr. It is held until mem_gnt.
- R5: A response with mem_err high ends the walk with fail high and fail_cause = 63. There is no TLB write and no fault-address write.
- R6: A committed refill raises tlb_we for one cycle. tlb_dside equals the request flag, tlb_index is vaddr[13:12], tlb_vpn is vaddr[31:12], and tlb_pte is the word read from memory.
- R7: The refill way comes from a counter that resets to 0 and is incremented before use, taking its low two bits. Successive committed refills therefore go to ways 1, 2, 3, 0, 1 and so on.
- R8: excv_we is high, with excv_value equal to the missing virtual address, exactly in the cycle tlb_we is high.
- R9: A probe request completes with done but writes neither the TLB nor the fault-address register, and it does not advance the way rotation.
- R10: Busy is high from the cycle after a request is accepted through the done or fail cycle. Requests presented while busy, including in the done or fail cycle, are ignored.
- R11: done and fail are single-cycle pulses and never coincide. With done, res_paddr = {pte[31:12], vaddr[11:0]} and res_ring = pte[5:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Missing virtual address |
| req_dside | input | 1 | 1 = data-side miss, 0 = instruction-side |
| req_probe | input | 1 | Build the translation without installing it |
| pt_base | input | 32 | Page-table base register |
| busy | output | 1 | Walk in progress |
| lk_req | output | 1 | Translation request for the entry address |
| lk_vaddr | output | 32 | Entry virtual address |
| lk_ack | input | 1 | Lookup answer valid |
| lk_ok | input | 1 | Lookup succeeded |
| lk_paddr | input | 32 | Physical address of the entry |
| lk_cause | input | 6 | Fault cause when lookup fails |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_err | input | 1 | Read ended in error |
| mem_rdata | input | 32 | Read data (page-table entry) |
| tlb_we | output | 1 | TLB write strobe |
| tlb_dside | output | 1 | Target TLB: 1 = data, 0 = instruction |
| tlb_way | output | 2 | Refill way |
| tlb_index | output | 2 | Entry index inside the way |
| tlb_vpn | output | 20 | Virtual page number |
| tlb_pte | output | 32 | Entry written |
| excv_we | output | 1 | Fault-address register write strobe |
| excv_value | output | 32 | Fault-address value |
| done | output | 1 | Walk completed successfully |
| fail | output | 1 | Walk aborted |
| fail_cause | output | 6 | Abort cause, valid with fail |
| res_paddr | output | 32 | Translated physical address, valid with done |
| res_ring | output | 2 | Ring of the entry, valid with done |

## Verification
The busy interlock and the completion pulse share a cycle. A request presented in the same cycle that done or fail is high must be dropped, because the walker only leaves its final state on that edge. The bench provokes this by driving req_valid in the done/fail cycle of many walks, and also while the walker waits on the lookup. It judges the result at the ports: one cycle later, busy and lk_req must both be low, and the TLB write observed for the walk must carry the original address and not the stray one.

// File: rtl/tlb_refill_pkg.sv
// Shared types for the TLB refill walker.
// Assumes: no more than eight sequencer states.
package tlb_refill_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_XLATE    = 3'd1,
        ST_MEM_REQ  = 3'd2,
        ST_MEM_WAIT = 3'd3,
        ST_WRITE    = 3'd4,
        ST_DONE     = 3'd5
    } walk_state_t;
endpackage

// File: rtl/refill_pte_addr.sv
// Forms the virtual address of a page-table entry from the base register and
// the missing address. Purely combinational. Assumes word-aligned entries.
module refill_pte_addr #(
    parameter int VA_W     = 32,
    parameter int PT_SHIFT = 10
) (
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] miss_vaddr,
    output logic [VA_W-1:0] entry_vaddr
);
    localparam logic [VA_W-1:0] ALIGN_MASK = ~(VA_W'(3));

    // Merge the shifted address into the base and word-align the result.
    always_comb begin
        entry_vaddr = (base | (miss_vaddr >> PT_SHIFT)) & ALIGN_MASK;
    end
endmodule

// File: rtl/refill_way_rot.sv
// Rotating refill-way selector. The counter resets to zero and advances once
// for every committed refill; the way offered is the incremented value.
// Assumes: 'advance' pulses for one cycle per committed write.
module refill_way_rot #(
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WAY_W-1:0] next_way
);
    logic [WAY_W-1:0] cnt_q;

    // Count committed refills.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    // Offer the pre-incremented value as the destination way.
    always_comb begin
        next_way = cnt_q + 1'b1;
    end
endmodule

// File: rtl/refill_ctrl.sv
// Walk sequencer. It accepts one request while idle, holds the lookup request
// until it is answered, issues one memory read, then either commits or ends.
// Assumes: the lookup and memory responders answer each request exactly once.
module refill_ctrl
    import tlb_refill_pkg::*;
#(
    parameter int VA_W          = 32,
    parameter int CAUSE_W       = 6,
    parameter int MEM_ERR_CAUSE = 63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_dside,
    input  logic               req_probe,
    input  logic [VA_W-1:0]    entry_vaddr,
    input  logic               lk_ack,
    input  logic               lk_ok,
    input  logic [VA_W-1:0]    lk_paddr,
    input  logic [CAUSE_W-1:0] lk_cause,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic               mem_err,
    input  logic [VA_W-1:0]    mem_rdata,
    output walk_state_t        state_o,
    output logic [VA_W-1:0]    vaddr_q,
    output logic               dside_q,
    output logic [VA_W-1:0]    entry_va_q,
    output logic [VA_W-1:0]    entry_pa_q,
    output logic [VA_W-1:0]    pte_q,
    output logic               err_q,
    output logic [CAUSE_W-1:0] cause_q
);
    localparam logic [CAUSE_W-1:0] MEM_CAUSE = CAUSE_W'(MEM_ERR_CAUSE);

    walk_state_t state_q;
    logic        probe_q;

    // Sequence the walk and capture its operands and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            vaddr_q    <= '0;
            dside_q    <= 1'b0;
            probe_q    <= 1'b0;
            entry_va_q <= '0;
            entry_pa_q <= '0;
            pte_q      <= '0;
            err_q      <= 1'b0;
            cause_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q    <= req_vaddr;
                        dside_q    <= req_dside;
                        probe_q    <= req_probe;
                        entry_va_q <= entry_vaddr;
                        err_q      <= 1'b0;
                        cause_q    <= '0;
                        state_q    <= ST_XLATE;
                    end
                end
                ST_XLATE: begin
                    if (lk_ack) begin
                        if (lk_ok) begin
                            entry_pa_q <= lk_paddr;
                            state_q    <= ST_MEM_REQ;
                        end else begin
                            err_q   <= 1'b1;
                            cause_q <= lk_cause;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_MEM_REQ: begin
                    if (mem_gnt) state_q <= ST_MEM_WAIT;
                end
                ST_MEM_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            err_q   <= 1'b1;
                            cause_q <= MEM_CAUSE;
                            state_q <= ST_DONE;
                        end else begin
                            pte_q   <= mem_rdata;
                            state_q <= probe_q ? ST_DONE : ST_WRITE;
                        end
                    end
                end
                ST_WRITE: state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/tlb_refill_walker.sv
// Top of the TLB refill walker: address former, sequencer and way rotation,
// plus the decode of the sequencer state into the port strobes.
// Assumes: pt_base is sampled in the cycle the request is accepted.
module tlb_refill_walker
    import tlb_refill_pkg::*;
#(
    parameter int VA_W          = 32,
    parameter int PAGE_SHIFT    = 12,
    parameter int IDX_W         = 2,
    parameter int WAY_W         = 2,
    parameter int CAUSE_W       = 6,
    parameter int PT_SHIFT      = 10,
    parameter int MEM_ERR_CAUSE = 63
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic                       req_dside,
    input  logic                       req_probe,
    input  logic [VA_W-1:0]            pt_base,
    output logic                       busy,
    output logic                       lk_req,
    output logic [VA_W-1:0]            lk_vaddr,
    input  logic                       lk_ack,
    input  logic                       lk_ok,
    input  logic [VA_W-1:0]            lk_paddr,
    input  logic [CAUSE_W-1:0]         lk_cause,
    output logic                       mem_req,
    output logic [VA_W-1:0]            mem_addr,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    input  logic                       mem_err,
    input  logic [VA_W-1:0]            mem_rdata,
    output logic                       tlb_we,
    output logic                       tlb_dside,
    output logic [WAY_W-1:0]           tlb_way,
    output logic [IDX_W-1:0]           tlb_index,
    output logic [VA_W-PAGE_SHIFT-1:0] tlb_vpn,
    output logic [VA_W-1:0]            tlb_pte,
    output logic                       excv_we,
    output logic [VA_W-1:0]            excv_value,
    output logic                       done,
    output logic                       fail,
    output logic [CAUSE_W-1:0]         fail_cause,
    output logic [VA_W-1:0]            res_paddr,
    output logic [1:0]                 res_ring
);
    localparam int RING_LSB = 4;

    logic [VA_W-1:0]    entry_vaddr;
    walk_state_t        state;
    logic [VA_W-1:0]    vaddr_q;
    logic               dside_q;
    logic [VA_W-1:0]    entry_va_q;
    logic [VA_W-1:0]    entry_pa_q;
    logic [VA_W-1:0]    pte_q;
    logic               err_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               commit;
    logic [WAY_W-1:0]   next_way;

    refill_pte_addr #(.VA_W(VA_W), .PT_SHIFT(PT_SHIFT)) u_addr (
        .base        (pt_base),
        .miss_vaddr  (req_vaddr),
        .entry_vaddr (entry_vaddr)
    );

    refill_ctrl #(.VA_W(VA_W), .CAUSE_W(CAUSE_W), .MEM_ERR_CAUSE(MEM_ERR_CAUSE)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .req_dside   (req_dside),
        .req_probe   (req_probe),
        .entry_vaddr (entry_vaddr),
        .lk_ack      (lk_ack),
        .lk_ok       (lk_ok),
        .lk_paddr    (lk_paddr),
        .lk_cause    (lk_cause),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .state_o     (state),
        .vaddr_q     (vaddr_q),
        .dside_q     (dside_q),
        .entry_va_q  (entry_va_q),
        .entry_pa_q  (entry_pa_q),
        .pte_q       (pte_q),
        .err_q       (err_q),
        .cause_q     (cause_q)
    );

    refill_way_rot #(.WAY_W(WAY_W)) u_rot (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (commit),
        .next_way (next_way)
    );

    // Decode sequencer state into handshake and completion strobes.
    always_comb begin
        commit  = (state == ST_WRITE);
        busy    = (state != ST_IDLE);
        lk_req  = (state == ST_XLATE);
        mem_req = (state == ST_MEM_REQ);
        done    = (state == ST_DONE) && !err_q;
        fail    = (state == ST_DONE) && err_q;
    end

    // Present addresses, TLB write fields and results.
    always_comb begin
        lk_vaddr   = entry_va_q;
        mem_addr   = entry_pa_q;
        tlb_we     = commit;
        tlb_dside  = dside_q;
        tlb_way    = next_way;
        tlb_index  = vaddr_q[PAGE_SHIFT +: IDX_W];
        tlb_vpn    = vaddr_q[VA_W-1:PAGE_SHIFT];
        tlb_pte    = pte_q;
        excv_we    = commit;
        excv_value = vaddr_q;
        fail_cause = fail ? cause_q : '0;
        res_paddr  = {pte_q[VA_W-1:PAGE_SHIFT], vaddr_q[PAGE_SHIFT-1:0]};
        res_ring   = pte_q[RING_LSB +: 2];
    end
endmodule

// File: rtl/refill_walker_checker.sv
// Protocol checker for the refill walker, attached by bind. It keeps its own
// model of the way rotation and relates strobes across cycles.
module refill_walker_checker #(
    parameter int VA_W  = 32,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             mem_req,
    input logic             tlb_we,
    input logic [WAY_W-1:0] tlb_way,
    input logic             excv_we,
    input logic             done,
    input logic             fail
);
    logic [WAY_W-1:0] refills_q;

    // Independent count of committed refills.
    always_ff @(posedge clk) begin
        if (!rst_n)      refills_q <= '0;
        else if (tlb_we) refills_q <= refills_q + 1'b1;
    end

    assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_vaddr[1:0] == 2'b00));

    assert_no_mem_during_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !lk_req && busy);

    assert_no_write_before_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !$past(tlb_we));

    assert_way_rotation_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we |-> (tlb_way == WAY_W'(refills_q + 1'b1)));

    assert_excv_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we == excv_we);

    assert_idle_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !busy);

    assert_stay_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

    assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, tlb_we}));

    assert_end_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !(done || fail));
endmodule

bind tlb_refill_walker refill_walker_checker #(.VA_W(VA_W), .WAY_W(WAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .lk_req    (lk_req),
    .lk_vaddr  (lk_vaddr),
    .mem_req   (mem_req),
    .tlb_we    (tlb_we),
    .tlb_way   (tlb_way),
    .excv_we   (excv_we),
    .done      (done),
    .fail      (fail)
);

// File: tb/tb_tlb_refill_walker.sv
module tb_tlb_refill_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_dside = 1'b0, req_probe = 1'b0;
    logic [31:0] req_vaddr = '0, pt_base = '0;
    logic        busy, lk_req, mem_req;
    logic [31:0] lk_vaddr, mem_addr;
    logic        lk_ack = 1'b0, lk_ok = 1'b0;
    logic [31:0] lk_paddr = '0;
    logic [5:0]  lk_cause = '0;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tlb_we, tlb_dside, excv_we, done, fail;
    logic [1:0]  tlb_way, tlb_index, res_ring;
    logic [19:0] tlb_vpn;
    logic [31:0] tlb_pte, excv_value, res_paddr;
    logic [5:0]  fail_cause;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, ex_cnt = 0, mreq_cnt = 0;
    logic [31:0] cap_pte, cap_excv;
    logic [1:0]  cap_way, cap_idx;
    logic [19:0] cap_vpn;
    logic        cap_ds;
    int          rot_cnt = 0;

    always #10 clk = ~clk;

    tlb_refill_walker dut (.*);

    // Record write strobes and memory requests as they appear.
    always @(negedge clk) begin
        if (tlb_we) begin
            wr_cnt++; cap_pte = tlb_pte; cap_way = tlb_way;
            cap_idx = tlb_index; cap_vpn = tlb_vpn; cap_ds = tlb_dside;
        end
        if (excv_we) begin ex_cnt++; cap_excv = excv_value; end
        if (mem_req) mreq_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry_va(input logic [31:0] base, input logic [31:0] va);
        return (base | (va >> 10)) & 32'hFFFF_FFFC;
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [31:0] pte, input logic [31:0] va);
        return {pte[31:12], va[11:0]};
    endfunction

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mode 0: success, 1: lookup fault, 2: memory error
    task automatic do_walk(input logic [31:0] va, input logic ds, input logic pr, input int mode,
                           input logic [31:0] base, input logic [31:0] pa, input logic [31:0] pte,
                           input logic [5:0] cause, input bit poke);
        logic [31:0] ev;
        wr_cnt = 0; ex_cnt = 0; mreq_cnt = 0;
        pt_base = base; req_vaddr = va; req_dside = ds; req_probe = pr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; pt_base = ~base;
        ev = exp_entry_va(base, va);
        check(busy && lk_req, "R10 busy after accept", {30'd0, busy, lk_req}, 32'd3);
        check(lk_vaddr == ev, "R2 entry address", lk_vaddr, ev);
        idle_cycles(int'($urandom_range(0, 2)));
        if (poke) begin req_valid = 1'b1; @(negedge clk); req_valid = 1'b0; end
        check(lk_req, "R2 lookup held until ack", {31'd0, lk_req}, 32'd1);
        lk_ack = 1'b1; lk_ok = (mode != 1); lk_paddr = pa; lk_cause = cause;
        @(negedge clk);
        lk_ack = 1'b0; lk_ok = 1'b0;
        if (mode != 1) begin
            check(mem_req && mem_addr == pa, "R4 memory address", mem_addr, pa);
            idle_cycles(int'($urandom_range(0, 2)));
            check(mem_req, "R4 request held until grant", {31'd0, mem_req}, 32'd1);
            mem_gnt = 1'b1; @(negedge clk); mem_gnt = 1'b0;
            idle_cycles(int'($urandom_range(0, 2)));
            mem_rvalid = 1'b1; mem_err = (mode == 2); mem_rdata = pte;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_err = 1'b0;
        end
        for (int k = 0; k < 4 && !(done || fail); k++) @(negedge clk);
        if (mode == 0) begin
            check(done && !fail, "R11 done pulse", {30'd0, done, fail}, 32'd2);
            check(res_paddr == exp_paddr(pte, va), "R11 result address", res_paddr, exp_paddr(pte, va));
            check(res_ring == pte[5:4], "R11 result ring", {30'd0, res_ring}, {30'd0, pte[5:4]});
            if (pr) begin
                check(wr_cnt == 0 && ex_cnt == 0, "R9 probe leaves state", wr_cnt, 0);
            end else begin
                rot_cnt++;
                check(wr_cnt == 1, "R6 one TLB write", wr_cnt, 1);
                check(cap_way == 2'(rot_cnt), "R7 refill way", {30'd0, cap_way}, {30'd0, 2'(rot_cnt)});
                check(cap_pte == pte && cap_ds == ds, "R6 entry and side", cap_pte, pte);
                check(cap_idx == va[13:12] && cap_vpn == va[31:12], "R6 index and vpn",
                      {10'd0, cap_vpn, cap_idx}, {10'd0, va[31:12], va[13:12]});
                check(ex_cnt == 1 && cap_excv == va, "R8 fault address", cap_excv, va);
            end
        end else begin
            check(fail && !done, "R11 fail pulse", {30'd0, done, fail}, 32'd1);
            check(wr_cnt == 0 && ex_cnt == 0, mode == 1 ? "R3 no write" : "R5 no write", wr_cnt, 0);
            if (mode == 1) begin
                check(fail_cause == cause, "R3 cause", {26'd0, fail_cause}, {26'd0, cause});
                check(mreq_cnt == 0, "R3 no memory read", mreq_cnt, 0);
            end else begin
                check(fail_cause == 6'd63, "R5 cause", {26'd0, fail_cause}, 32'd63);
            end
        end
        req_valid = 1'b1; req_vaddr = va ^ 32'h5000;
        @(negedge clk);
        req_valid = 1'b0;
        check(!busy && !lk_req, "R10 request in end cycle ignored", {30'd0, busy, lk_req}, 32'd0);
        check(!done && !fail, "R11 single pulse", {30'd0, done, fail}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !lk_req && !mem_req && !tlb_we && !excv_we && !done && !fail,
              "R1 reset state", {25'd0, busy, lk_req, mem_req, tlb_we, excv_we, done, fail}, 32'd0);
        // Directed corners: overlapping base bits, all-ones address, probe, both faults.
        do_walk(32'hFFFF_FFFF, 1'b1, 1'b0, 0, 32'hFFC0_0000, 32'h0000_1FFC, 32'hABCD_E030, 6'd0, 1'b1);
        do_walk(32'h1234_5678, 1'b0, 1'b1, 0, 32'h8000_0000, 32'h0040_0010, 32'h0101_1010, 6'd0, 1'b0);
        do_walk(32'h0000_3000, 1'b1, 1'b0, 1, 32'h4000_0000, 32'h0, 32'h0, 6'd24, 1'b1);
        do_walk(32'h0000_3000, 1'b0, 1'b0, 2, 32'h4000_0000, 32'h100, 32'h0, 6'd0, 1'b0);
        for (int t = 0; t < 60; t++) begin
            int r = int'($urandom_range(0, 9));
            do_walk($urandom, 1'($urandom), ($urandom_range(0, 3) == 0),
                    (r < 6) ? 0 : ((r < 8) ? 1 : 2), $urandom, $urandom, $urandom,
                    6'($urandom_range(1, 40)), 1'($urandom));
            idle_cycles(int'($urandom_range(0, 2)));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule